// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from four source classes and offers one request at a time to the processor: hardware failure, program exception (overflow, divide by zero, illegal operation, access violation), the processor's periodic timer, and I/O completion or error. The controller drives a request line and a vector that names the chosen source. The processor answers with an acknowledge when it enters the handler and with an end-of-handler strobe when it returns. The controller also reports which handler level is active at the moment.

A mode input picks one of two servicing policies. In sequential mode, new interrupts are held off while any handler runs. Requests that arrive in the meantime stay pending and are granted oldest first once the handler finishes. In nested mode, a request that outranks every running handler is presented at once and preempts it. An in-service mask acts as a stack of preempted levels, so each end-of-handler returns control to the handler that was interrupted. Saving processor context is left to the processor.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source indices and fixed priority: index 3 is hardware failure (highest), 2 is program exception, 1 is timer and 0 is I/O (lowest). `vectorOut` carries the index of the presented source.
- R2: A 0-to-1 change on `reqIn[i]` makes source i pending from the next clock edge. The pending state lasts until source i is acknowledged. A request held high after acknowledge does not make the source pending again until it falls and rises once more.
- R3: In sequential mode (`nestMode` = 0), `irqOut` stays low while any handler is active, and requests that arrive during that time stay pending.
- R4: In sequential mode, pending sources are presented in their order of arrival. Sources that arrive in the same cycle are ordered by priority, with the higher index first.
- R5: In nested mode (`nestMode` = 1), `irqOut` is high when a source is pending and either no handler is active or the highest pending index is above the active level. `vectorOut` is the highest pending index. A pending source of equal or lower priority waits.
- R6: An acknowledge while `irqOut` is high makes the presented source active from the next edge: `activeLevel` equals the acknowledged vector and its pending state clears. An acknowledge while `irqOut` is low has no effect.
- R7: End-of-handler retires the highest active level. `activeLevel` then falls back to the next lower active level that is still recorded, and `activeValid` goes low once no level remains.
- R8: After reset no source is pending and no level is active, so `irqOut` and `activeValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | 4 | Request lines, one per source, bit index = source index |
| nestMode | input | 1 | 1 = nested priority policy, 0 = sequential policy |
| ackIn | input | 1 | Processor acknowledges the presented interrupt |
| eoiIn | input | 1 | Processor signals the end of the current handler |
| irqOut | output | 1 | Interrupt request to the processor |
| vectorOut | output | 2 | Index of the presented source |
| activeValid | output | 1 | At least one handler level is active |
| activeLevel | output | 2 | Highest active handler level |

## Verification
The hardest states to reach are a stack of several preempted levels and a sequential backlog in which a lower-priority source arrived before a higher one. The bench builds each of them through the ports alone, using one-cycle request pulses, acknowledges and end-of-handler strobes in a fixed order. It sweeps every ordered pair of sources in both modes and works out the expected preemption and grant order from the index comparison. It also stacks three nested levels and unwinds them one end-of-handler at a time.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int NUM_SRC = 4;
  localparam int IDX_W   = $clog2(NUM_SRC);

  typedef struct packed {
    logic             take;     // accept the presented source
    logic [IDX_W-1:0] takeIdx;  // which source is accepted
    logic             retire;   // drop the highest in-service level
  } intcStrobe_t;

  function automatic logic [IDX_W-1:0] topOf(input logic [NUM_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/intc_datapath.sv
`timescale 1ns/1ps
module intc_datapath
  import intc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  intcStrobe_t        strobe,
  output logic [NUM_SRC-1:0] pendingQ,
  output logic [NUM_SRC-1:0] inServiceQ,
  output logic [IDX_W-1:0]   oldestIdx,
  output logic [IDX_W-1:0]   topPendIdx,
  output logic [IDX_W-1:0]   topServIdx
);
  localparam int MAT_W = NUM_SRC * NUM_SRC;

  logic [NUM_SRC-1:0] reqPrev;
  logic [NUM_SRC-1:0] rise, takeMask, retireMask, keep, fresh;
  logic [MAT_W-1:0]   olderQ;   // bit i*NUM_SRC+j: source i arrived before j
  logic [NUM_SRC-1:0] blocked;

  assign rise       = reqIn & ~reqPrev;
  assign takeMask   = strobe.take ? (NUM_SRC'(1) << strobe.takeIdx) : '0;
  assign retireMask = (strobe.retire && |inServiceQ) ? (NUM_SRC'(1) << topServIdx) : '0;
  assign keep       = pendingQ & ~takeMask;
  assign fresh      = rise & ~keep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPrev    <= '0;
      pendingQ   <= '0;
      inServiceQ <= '0;
    end else begin
      reqPrev    <= reqIn;
      pendingQ   <= keep | rise;
      inServiceQ <= (inServiceQ & ~retireMask) | takeMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      olderQ <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        for (int j = 0; j < NUM_SRC; j++) begin
          if (i != j) begin
            if (fresh[i] && fresh[j])
              olderQ[i*NUM_SRC+j] <= (i > j);
            else if (fresh[i])
              olderQ[i*NUM_SRC+j] <= 1'b0;
            else if (fresh[j])
              olderQ[i*NUM_SRC+j] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < NUM_SRC; j++)
        if (j != i) blocked[i] = blocked[i] | (pendingQ[j] & olderQ[j*NUM_SRC+i]);
    end
  end

  always_comb begin
    oldestIdx = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (pendingQ[i] && !blocked[i]) oldestIdx = IDX_W'(i);
  end

  assign topPendIdx = topOf(pendingQ);
  assign topServIdx = topOf(inServiceQ);
endmodule

// File: rtl/intc_ctrl.sv
`timescale 1ns/1ps
module intc_ctrl
  import intc_pkg::*;
(
  input  logic               nestMode,
  input  logic               ackIn,
  input  logic               eoiIn,
  input  logic [NUM_SRC-1:0] pendingQ,
  input  logic [NUM_SRC-1:0] inServiceQ,
  input  logic [IDX_W-1:0]   oldestIdx,
  input  logic [IDX_W-1:0]   topPendIdx,
  input  logic [IDX_W-1:0]   topServIdx,
  output logic               irqOut,
  output logic [IDX_W-1:0]   vectorOut,
  output logic               activeValid,
  output logic [IDX_W-1:0]   activeLevel,
  output intcStrobe_t        strobe
);
  logic anyPend, anyServ;

  assign anyPend = |pendingQ;
  assign anyServ = |inServiceQ;

  always_comb begin
    if (nestMode) begin
      irqOut    = anyPend && (!anyServ || (topPendIdx > topServIdx));
      vectorOut = topPendIdx;
    end else begin
      irqOut    = anyPend && !anyServ;
      vectorOut = oldestIdx;
    end
  end

  assign strobe.take    = ackIn && irqOut;
  assign strobe.takeIdx = vectorOut;
  assign strobe.retire  = eoiIn && anyServ;

  assign activeValid = anyServ;
  assign activeLevel = topServIdx;
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
  import intc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               nestMode,
  input  logic               ackIn,
  input  logic               eoiIn,
  output logic               irqOut,
  output logic [IDX_W-1:0]   vectorOut,
  output logic               activeValid,
  output logic [IDX_W-1:0]   activeLevel
);
  intcStrobe_t        strobe;
  logic [NUM_SRC-1:0] pendingQ, inServiceQ;
  logic [IDX_W-1:0]   oldestIdx, topPendIdx, topServIdx;

  intc_datapath i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .reqIn      (reqIn),
    .strobe     (strobe),
    .pendingQ   (pendingQ),
    .inServiceQ (inServiceQ),
    .oldestIdx  (oldestIdx),
    .topPendIdx (topPendIdx),
    .topServIdx (topServIdx)
  );

  intc_ctrl i_ctrl (
    .nestMode    (nestMode),
    .ackIn       (ackIn),
    .eoiIn       (eoiIn),
    .pendingQ    (pendingQ),
    .inServiceQ  (inServiceQ),
    .oldestIdx   (oldestIdx),
    .topPendIdx  (topPendIdx),
    .topServIdx  (topServIdx),
    .irqOut      (irqOut),
    .vectorOut   (vectorOut),
    .activeValid (activeValid),
    .activeLevel (activeLevel),
    .strobe      (strobe)
  );
endmodule

// File: rtl/prio_irq_ctrl_checker.sv
`timescale 1ns/1ps
module prio_irq_ctrl_checker
  import intc_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             nestMode,
  input logic             ackIn,
  input logic             eoiIn,
  input logic             irqOut,
  input logic [IDX_W-1:0] vectorOut,
  input logic             activeValid,
  input logic [IDX_W-1:0] activeLevel
);
  assert_seq_holdoff_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!nestMode && activeValid) |-> !irqOut);

  assert_nest_outranks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (nestMode && irqOut && activeValid) |-> (vectorOut > activeLevel));

  assert_ack_enters_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && irqOut) |=> (activeValid && activeLevel == $past(vectorOut)));

  assert_ack_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && !irqOut && !eoiIn) |=> ($stable(activeValid) && $stable(activeLevel)));

  assert_eoi_falls_R7: assert property (@(posedge clk) disable iff (!rstN)
    (eoiIn && !ackIn && activeValid) |=> (!activeValid || activeLevel < $past(activeLevel)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_checker i_checker (
  .clk         (clk),
  .rstN        (rstN),
  .nestMode    (nestMode),
  .ackIn       (ackIn),
  .eoiIn       (eoiIn),
  .irqOut      (irqOut),
  .vectorOut   (vectorOut),
  .activeValid (activeValid),
  .activeLevel (activeLevel)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] reqIn = '0;
  logic       nestMode = 1'b0;
  logic       ackIn = 1'b0;
  logic       eoiIn = 1'b0;
  logic       irqOut, activeValid;
  logic [1:0] vectorOut, activeLevel;
  int testCount = 0;
  int failCount = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .nestMode(nestMode),
    .ackIn(ackIn), .eoiIn(eoiIn), .irqOut(irqOut), .vectorOut(vectorOut),
    .activeValid(activeValid), .activeLevel(activeLevel)
  );

  task automatic checkVal(string tag, int actual, int expected);
    testCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic resetDut(logic mode);
    rstN = 1'b0; reqIn = '0; ackIn = 1'b0; eoiIn = 1'b0; nestMode = mode;
    step(); step();
    rstN = 1'b1;
    step();
  endtask

  task automatic pulse(logic [3:0] mask);
    reqIn = mask; step(); reqIn = '0;
  endtask

  task automatic doAck();
    ackIn = 1'b1; step(); ackIn = 1'b0;
  endtask

  task automatic doEoi();
    eoiIn = 1'b1; step(); eoiIn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    // R8: reset state
    resetDut(1'b1);
    checkVal("R8 irq after reset", irqOut, 0);
    checkVal("R8 active after reset", activeValid, 0);

    // R6: acknowledge without a request is ignored
    doAck();
    checkVal("R6 stray ack active", activeValid, 0);

    // Nested sweep over every ordered pair of sources
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        resetDut(1'b1);
        pulse(4'(1 << a));
        checkVal("R1 vector index", vectorOut, a);
        checkVal("R2 pending raises irq", irqOut, 1);
        doAck();
        checkVal("R6 level after ack", activeLevel, a);
        checkVal("R6 pending cleared", irqOut, 0);
        pulse(4'(1 << b));
        checkVal("R5 preempt decision", irqOut, (b > a) ? 1 : 0);
        if (b > a) begin
          checkVal("R5 vector highest", vectorOut, b);
          doAck();
          checkVal("R6 nested level", activeLevel, b);
          doEoi();
          checkVal("R7 return to preempted", activeLevel, a);
          checkVal("R7 still active", activeValid, 1);
          doEoi();
          checkVal("R7 empty after unwind", activeValid, 0);
        end else begin
          doEoi();
          checkVal("R7 empty after eoi", activeValid, 0);
          checkVal("R5 waiting source presented", irqOut, 1);
          checkVal("R5 waiting vector", vectorOut, b);
        end
      end
    end

    // R7: three-deep nesting unwinds level by level
    resetDut(1'b1);
    pulse(4'b0001); doAck();
    pulse(4'b0010); doAck();
    pulse(4'b1000); doAck();
    checkVal("R7 depth three top", activeLevel, 3);
    doEoi();
    checkVal("R7 back to timer", activeLevel, 1);
    doEoi();
    checkVal("R7 back to io", activeLevel, 0);
    doEoi();
    checkVal("R7 stack empty", activeValid, 0);

    // Sequential sweep: arrival order wins over priority
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        if (a != b) begin
          resetDut(1'b0);
          pulse(4'(1 << a));
          pulse(4'(1 << b));
          checkVal("R4 oldest first", vectorOut, a);
          doAck();
          checkVal("R6 seq level", activeLevel, a);
          checkVal("R3 held off while active", irqOut, 0);
          doEoi();
          checkVal("R3 retained request", irqOut, 1);
          checkVal("R4 second arrival", vectorOut, b);
          doAck(); doEoi();
          checkVal("R7 seq drained", activeValid, 0);
        end
      end
    end

    // R4: simultaneous arrivals ordered by priority
    resetDut(1'b0);
    pulse(4'b0101);
    checkVal("R4 tie higher first", vectorOut, 2);
    doAck(); doEoi();
    checkVal("R4 tie lower next", vectorOut, 0);

    // R2: a held request does not re-arm
    resetDut(1'b0);
    reqIn = 4'b0010; step();
    checkVal("R2 held rise pending", irqOut, 1);
    doAck(); step(); doEoi(); step();
    checkVal("R2 held level no rearm", irqOut, 0);
    reqIn = '0; step();
    pulse(4'b0010);
    checkVal("R2 new edge rearms", irqOut, 1);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule